// File: doc/BRIEF.md
# Watershed Flooding Labeller

This block segments a small grayscale image held in on-chip memory by flooding from marker seeds. The host first fills two pixel memories through a plain address/data port. The altitude memory holds the image or its gradient. The label memory holds seed regions, each with its own nonzero label. A start pulse begins the run. The block queues every unlabelled pixel that touches a seed, then takes pixels one at a time from the lowest non-empty altitude level. Each taken pixel is coloured from its labelled neighbours, and its fresh neighbours are queued in turn.

Where two different basins meet, the pixel becomes a separator and gets the reserved label 0xFF. When the queue has drained, done rises and the host reads the labelled image back through the same port. The run length depends on the image content. With the default 16x16 image it is about four cycles per pixel to seed the queue, plus up to ten cycles per flooded pixel.

Top module: `wshed_flood`

## Requirements
- R1: After reset, busy_o and done_o are low and rdata_o is 0.
- R2: While idle, wr_en_i writes wdata_i at pixel addr_i (index = row*IMG_W + col) into the altitude memory when sel_i=0, or into the label memory when sel_i=1. In every cycle, rdata_o shows the word of the selected memory at addr_i one cycle later. Flooding never changes altitudes.
- R3: A start_i pulse while idle raises busy_o on the next cycle. A start_i while busy has no effect on the run.
- R4: Seeding visits pixels in ascending index order. Each pixel with label 0 that has a 4-neighbour with a label in 1..254 is queued once, at the level equal to its own altitude.
- R5: Each step takes the oldest pixel from the lowest non-empty altitude level. Pixels within one level come out first in, first out.
- R6: A taken pixel whose labelled neighbours (labels 1..254) all carry one label receives that label.
- R7: A taken pixel whose labelled neighbours carry two or more different labels receives 0xFF and queues none of its neighbours.
- R8: After a taken pixel gets a basin label, its in-image neighbours with label 0 that were never queued are queued at their own altitude. They are visited in the order north, west, east, south, and positions outside the border are skipped.
- R9: When every level is empty, busy_o falls and done_o rises in the same cycle. done_o stays high until the next start. Seed labels are preserved.
- R10: Host writes while busy_o is high change neither memory.
- R11: An image with no seeds finishes within 4*IMG_W*IMG_H+4 cycles of start with every label still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a flooding run (idle only) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished; held until next start |
| wr_en_i | input | 1 | Host write strobe |
| sel_i | input | 1 | Memory select: 0 altitude, 1 label |
| addr_i | input | PIX_W | Pixel index |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Selected memory word, one cycle after addr_i |

## Verification
A corrupted queue link, a level bit that is set wrongly, or a queued flag that is lost changes the visiting order. This appears only after done, as a pixel with the wrong basin or a missing or extra 0xFF separator at a basin boundary. The bench therefore compares the complete label image of several contrasting images against an independent flooding model. A stuck control state instead shows at once as done_o never rising, or as busy_o and done_o out of step. A seeding fault on an unseeded image shows up as a finish time beyond the seeding bound.

// File: rtl/wshed_pkg.sv
package wshed_pkg;
  typedef enum logic [1:0] {DIR_N, DIR_W, DIR_E, DIR_S} dir_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_POP, ST_GATHER, ST_WRITE, ST_SPREAD
  } state_e;
endpackage

// File: rtl/wshed_nbr.sv
module wshed_nbr #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 16,
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix_i,
  input  wshed_pkg::dir_e  dir_i,
  output logic [PIX_W-1:0] nbr_o,
  output logic             valid_o
);
  int row, col, nrow, ncol;

  always_comb begin
    row  = int'(pix_i) / IMG_W;
    col  = int'(pix_i) % IMG_W;
    nrow = row;
    ncol = col;
    unique case (dir_i)
      wshed_pkg::DIR_N: begin valid_o = (row > 0);         nrow = row - 1; end
      wshed_pkg::DIR_W: begin valid_o = (col > 0);         ncol = col - 1; end
      wshed_pkg::DIR_E: begin valid_o = (col < IMG_W - 1); ncol = col + 1; end
      default:          begin valid_o = (row < IMG_H - 1); nrow = row + 1; end
    endcase
    if (!valid_o) begin
      nrow = row;
      ncol = col;
    end
    nbr_o = PIX_W'(nrow * IMG_W + ncol);
  end
endmodule

// File: rtl/wshed_prio.sv
module wshed_prio #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wshed_hq.sv
module wshed_hq #(
  parameter int NPIX  = 256,
  parameter int PIX_W = 8,
  parameter int LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [PIX_W-1:0] push_pix_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [PIX_W-1:0] head_pix_o,
  output logic [LVL_W-1:0] head_lvl_o
);
  localparam int LEVELS = 1 << LVL_W;

  // one linked list per level; a pixel is in at most one list once
  logic [PIX_W-1:0]  head_q [LEVELS];
  logic [PIX_W-1:0]  tail_q [LEVELS];
  logic [PIX_W-1:0]  link_q [NPIX];
  logic [LEVELS-1:0] ne_q;
  logic              any;
  logic              last;

  wshed_prio #(.N(LEVELS), .IDX_W(LVL_W)) u_prio (
    .req_i (ne_q),
    .any_o (any),
    .idx_o (head_lvl_o)
  );

  assign empty_o    = !any;
  assign head_pix_o = head_q[head_lvl_o];
  assign last       = (head_q[head_lvl_o] == tail_q[head_lvl_o]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ne_q <= '0;
    end else if (clear_i) begin
      ne_q <= '0;
    end else if (pop_i && any) begin
      if (last) ne_q[head_lvl_o] <= 1'b0;
    end else if (push_i) begin
      ne_q[push_lvl_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!clear_i) begin
      if (pop_i && any) begin
        if (!last) head_q[head_lvl_o] <= link_q[head_pix_o];
      end else if (push_i) begin
        if (ne_q[push_lvl_i]) link_q[tail_q[push_lvl_i]] <= push_pix_i;
        else                  head_q[push_lvl_i]         <= push_pix_i;
        tail_q[push_lvl_i] <= push_pix_i;
      end
    end
  end
endmodule

// File: rtl/wshed_flood.sv
module wshed_flood #(
  parameter int IMG_W  = 16,
  parameter int IMG_H  = 16,
  parameter int DATA_W = 8,
  localparam int NPIX  = IMG_W * IMG_H,
  localparam int PIX_W = $clog2(NPIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              wr_en_i,
  input  logic              sel_i,
  input  logic [PIX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import wshed_pkg::*;

  localparam logic [DATA_W-1:0] WS = '1;

  logic [DATA_W-1:0] alt_mem [NPIX];
  logic [DATA_W-1:0] lab_mem [NPIX];
  logic [NPIX-1:0]   queued_q;

  state_e            state_q;
  logic [PIX_W-1:0]  scan_q, cur_q;
  logic [1:0]        dir_q;
  logic [DATA_W-1:0] acc_q;
  logic              conf_q, done_q;
  logic [DATA_W-1:0] rdata_q;

  logic [PIX_W-1:0]  ctr_pix, nbr_pix;
  logic              nbr_valid, nbr_lab_ok;
  logic [DATA_W-1:0] nbr_lab, nbr_alt;
  logic              init_push, spread_push;
  logic              hq_push, hq_pop, hq_empty, hq_clear;
  logic [PIX_W-1:0]  push_pix, hq_head_pix;
  logic [DATA_W-1:0] push_lvl, hq_head_lvl;
  logic              fsm_lab_we, host_we, idle;
  logic [DATA_W-1:0] fsm_lab_wd;

  assign idle    = (state_q == ST_IDLE);
  assign host_we = wr_en_i && idle;
  assign ctr_pix = (state_q == ST_INIT) ? scan_q : cur_q;

  wshed_nbr #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_nbr (
    .pix_i   (ctr_pix),
    .dir_i   (dir_e'(dir_q)),
    .nbr_o   (nbr_pix),
    .valid_o (nbr_valid)
  );

  assign nbr_lab    = lab_mem[nbr_pix];
  assign nbr_alt    = alt_mem[nbr_pix];
  assign nbr_lab_ok = nbr_valid && (nbr_lab != '0) && (nbr_lab != WS);

  assign init_push   = (state_q == ST_INIT) && (lab_mem[scan_q] == '0) &&
                       !queued_q[scan_q] && nbr_lab_ok;
  assign spread_push = (state_q == ST_SPREAD) && nbr_valid &&
                       (nbr_lab == '0) && !queued_q[nbr_pix];
  assign hq_push  = init_push || spread_push;
  assign push_pix = init_push ? scan_q : nbr_pix;
  assign push_lvl = init_push ? alt_mem[scan_q] : nbr_alt;
  assign hq_pop   = (state_q == ST_POP) && !hq_empty;
  assign hq_clear = idle && start_i;

  assign fsm_lab_we = (state_q == ST_WRITE);
  assign fsm_lab_wd = (conf_q || acc_q == '0) ? WS : acc_q;

  wshed_hq #(.NPIX(NPIX), .PIX_W(PIX_W), .LVL_W(DATA_W)) u_hq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (hq_clear),
    .push_i     (hq_push),
    .push_pix_i (push_pix),
    .push_lvl_i (push_lvl),
    .pop_i      (hq_pop),
    .empty_o    (hq_empty),
    .head_pix_o (hq_head_pix),
    .head_lvl_o (hq_head_lvl)
  );

  // pixel memories: host owns them while idle, the flood while busy
  always_ff @(posedge clk_i) begin
    if (host_we && !sel_i) alt_mem[addr_i] <= wdata_i;
    if (host_we && sel_i)  lab_mem[addr_i] <= wdata_i;
    else if (fsm_lab_we)   lab_mem[cur_q]  <= fsm_lab_wd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       queued_q <= '0;
    else if (hq_clear) queued_q <= '0;
    else if (hq_push)  queued_q[push_pix] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= sel_i ? lab_mem[addr_i] : alt_mem[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scan_q  <= '0;
      cur_q   <= '0;
      dir_q   <= '0;
      acc_q   <= '0;
      conf_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q  <= 1'b0;
            scan_q  <= '0;
            dir_q   <= '0;
            state_q <= ST_INIT;
          end
        end
        ST_INIT: begin
          dir_q <= dir_q + 2'd1;
          if (dir_q == 2'd3) begin
            if (scan_q == PIX_W'(NPIX - 1)) state_q <= ST_POP;
            else                            scan_q  <= scan_q + 1'b1;
          end
        end
        ST_POP: begin
          if (hq_empty) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_q   <= hq_head_pix;
            acc_q   <= '0;
            conf_q  <= 1'b0;
            dir_q   <= '0;
            state_q <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (nbr_lab_ok) begin
            if (acc_q == '0)          acc_q  <= nbr_lab;
            else if (nbr_lab != acc_q) conf_q <= 1'b1;
          end
          dir_q <= dir_q + 2'd1;
          if (dir_q == 2'd3) state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          dir_q   <= '0;
          state_q <= (fsm_lab_wd == WS) ? ST_POP : ST_SPREAD;
        end
        ST_SPREAD: begin
          dir_q <= dir_q + 2'd1;
          if (dir_q == 2'd3) state_q <= ST_POP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = !idle;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wshed_flood_chk.sv
module wshed_flood_chk #(
  parameter int NPIX   = 256,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              hq_push,
  input logic              hq_pop,
  input logic              hq_empty,
  input logic [PIX_W-1:0]  push_pix,
  input logic [NPIX-1:0]   queued_q,
  input logic              fsm_lab_we,
  input logic [DATA_W-1:0] fsm_lab_wd
);
  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  a_r3_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r9_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r9_done_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(hq_empty));

  a_r5_one_queue_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hq_push && hq_pop));

  a_r8_push_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hq_push |-> !queued_q[push_pix]);

  a_r6_no_blank_label: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_lab_we |-> fsm_lab_wd != '0);
endmodule

bind wshed_flood wshed_flood_chk #(.NPIX(NPIX), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .hq_push    (hq_push),
  .hq_pop     (hq_pop),
  .hq_empty   (hq_empty),
  .push_pix   (push_pix),
  .queued_q   (queued_q),
  .fsm_lab_we (fsm_lab_we),
  .fsm_lab_wd (fsm_lab_wd)
);

// File: tb/sim_wshed_flood.sv
module sim_wshed_flood;
  localparam int CLK_NS = 10;
  localparam int W  = 16;
  localparam int H  = 16;
  localparam int NP = W * H;
  localparam int LV = 256;

  logic       clk, rst_n;
  logic       start, busy, done, wr_en, sel;
  logic [7:0] addr, wdata, rdata;

  wshed_flood #(.IMG_W(W), .IMG_H(H), .DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .wr_en_i(wr_en), .sel_i(sel), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  int    n_total = 0, n_bad = 0;
  int    exp_q[$];
  string mon_req = "";
  bit    rd_go = 1'b0, mon_v = 1'b0;
  int    img_alt[NP], img_lab[NP], mdl_lab[NP];
  int    hq_buf[LV][NP];
  int    hq_hd[LV], hq_tl[LV];
  int unsigned seed;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each readback word against the scoreboard
  always @(posedge clk) mon_v <= rd_go;
  always @(negedge clk) begin
    if (mon_v) begin
      int e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      chk(int'(rdata) == e, mon_req, int'(rdata), e);
    end
  end

  function automatic int nb(input int p, input int d);
    int r, c;
    r = p / W; c = p % W;
    case (d)
      0: return (r > 0)     ? p - W : -1;
      1: return (c > 0)     ? p - 1 : -1;
      2: return (c < W - 1) ? p + 1 : -1;
      default: return (r < H - 1) ? p + W : -1;
    endcase
  endfunction

  function automatic bit is_basin(input int l);
    return (l != 0) && (l != 255);
  endfunction

  // reference flood built from R4..R8
  task automatic model();
    bit qd[NP];
    int lv, p, acc, n;
    bit conf;
    for (int i = 0; i < NP; i++) begin mdl_lab[i] = img_lab[i]; qd[i] = 0; end
    for (int i = 0; i < LV; i++) begin hq_hd[i] = 0; hq_tl[i] = 0; end
    for (int i = 0; i < NP; i++)
      for (int d = 0; d < 4; d++) begin
        n = nb(i, d);
        if (mdl_lab[i] == 0 && !qd[i] && n >= 0 && is_basin(mdl_lab[n])) begin
          hq_buf[img_alt[i]][hq_tl[img_alt[i]]++] = i; qd[i] = 1;
        end
      end
    forever begin
      lv = -1;
      for (int i = LV - 1; i >= 0; i--) if (hq_hd[i] != hq_tl[i]) lv = i;
      if (lv < 0) break;
      p = hq_buf[lv][hq_hd[lv]++];
      acc = 0; conf = 0;
      for (int d = 0; d < 4; d++) begin
        n = nb(p, d);
        if (n >= 0 && is_basin(mdl_lab[n])) begin
          if (acc == 0) acc = mdl_lab[n];
          else if (mdl_lab[n] != acc) conf = 1;
        end
      end
      mdl_lab[p] = (conf || acc == 0) ? 255 : acc;
      if (mdl_lab[p] != 255)
        for (int d = 0; d < 4; d++) begin
          n = nb(p, d);
          if (n >= 0 && mdl_lab[n] == 0 && !qd[n]) begin
            hq_buf[img_alt[n]][hq_tl[img_alt[n]]++] = n; qd[n] = 1;
          end
        end
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_wr(input bit s, input int a, input int d);
    wr_en = 1'b1; sel = s; addr = 8'(a); wdata = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic load_image();
    for (int p = 0; p < NP; p++) begin
      host_wr(1'b0, p, img_alt[p]);
      host_wr(1'b1, p, img_lab[p]);
    end
  endtask

  // driver: queues expected words, then sweeps addresses
  task automatic read_back(input bit s, input string req);
    if (s) model();
    mon_req = req;
    for (int p = 0; p < NP; p++) exp_q.push_back(s ? mdl_lab[p] : img_alt[p]);
    for (int p = 0; p < NP; p++) begin
      sel = s; addr = 8'(p); rd_go = 1'b1;
      tick();
    end
    rd_go = 1'b0;
    tick(); tick();
  endtask

  task automatic run(input bit poke, output int cyc);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy one cycle after start", int'(busy), 1);
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 60) begin
        host_wr(1'b1, 0, 7);   // R10 label write while busy
        host_wr(1'b0, 5, 0);   // R10 altitude write while busy
        start = 1'b1;          // R3 start while busy
        tick();
        start = 1'b0;
        cyc += 3;
      end else begin
        tick();
        cyc++;
      end
    end
    chk(done == 1'b1, "R9 done rises", int'(done), 1);
    chk(busy == 1'b0, "R9 busy falls with done", int'(busy), 0);
  endtask

  function automatic int rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return int'((seed >> 8) & 32'hFF);
  endfunction

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; sel = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(rdata == 8'd0, "R1 rdata after reset", int'(rdata), 0);

    // image A: two seeds either side of a central ridge
    for (int p = 0; p < NP; p++) begin
      int c;
      c = p % W;
      img_alt[p] = ((c < 8) ? 10 * c : 10 * (15 - c)) + (p / W);
      img_lab[p] = 0;
    end
    img_lab[8 * W + 0]  = 1;
    img_lab[8 * W + 15] = 2;
    load_image();
    run(1'b0, cyc);
    read_back(1'b1, "R6 R7 R8 ridge image labels");
    read_back(1'b0, "R2 altitude kept after flood");
    repeat (5) tick();
    chk(done == 1'b1, "R9 done held while idle", int'(done), 1);

    // image B: random relief, three seeds, pokes while busy
    seed = 32'h1234_5678;
    for (int p = 0; p < NP; p++) begin img_alt[p] = rnd(); img_lab[p] = 0; end
    img_lab[17] = 3; img_lab[120] = 5; img_lab[230] = 9;
    load_image();
    run(1'b1, cyc);
    read_back(1'b1, "R5 R10 R3 random relief labels");
    read_back(1'b0, "R10 altitude untouched by busy write");

    // image C: flat plateau, one seed floods everything
    for (int p = 0; p < NP; p++) begin img_alt[p] = 40; img_lab[p] = 0; end
    img_lab[119] = 4;
    load_image();
    run(1'b0, cyc);
    read_back(1'b1, "R4 R6 flat single basin");

    // image D: two seeds on flat ground meet halfway
    for (int p = 0; p < NP; p++) begin img_alt[p] = 7; img_lab[p] = 0; end
    img_lab[0] = 20; img_lab[NP - 1] = 21;
    load_image();
    run(1'b0, cyc);
    read_back(1'b1, "R5 R7 equal-level fronts");

    // image E: no seeds
    seed = 32'hCAFE_0001;
    for (int p = 0; p < NP; p++) begin img_alt[p] = rnd(); img_lab[p] = 0; end
    load_image();
    run(1'b0, cyc);
    chk(cyc <= 4 * NP + 4, "R11 unseeded finish time", cyc, 4 * NP + 4);
    read_back(1'b1, "R11 unseeded labels stay 0");

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule